// File: doc/BRIEF.md
# Subnormal Renormaliser to Two's-Complement-Exponent Form

This block accepts one single-precision floating-point word per clock, qualified by a valid bit. When the word is subnormal (exponent field zero, fraction non-zero), the block finds the fraction's leading one. It then moves that one into the implicit integer position and writes an exponent field that is read as a two's-complement number with the usual bias of 127. The encoded value does not change. Every other word (zeros, normals, infinities, NaNs) leaves the block bit-for-bit unchanged. A separate flag marks results that are in the renormalised form.

A later arithmetic stage can then treat every non-zero finite operand as having an implicit leading one. It needs only the flag to know that the exponent field is signed. The result is registered once, so output valid trails input valid by exactly one clock.

A two-state machine tracks whether the output register holds a fresh result. The states are ST_IDLE and ST_LOADED. The transitions are:
- T_ACCEPT: any state to ST_LOADED when `in_valid` is high.
- T_DRAIN: any state to ST_IDLE when `in_valid` is low.

Reset forces ST_IDLE.

Top module: `dnw_conv`

## Requirements
- R1: After reset is applied, `out_valid`, `out_wrapped` and every bit of `out_word` read zero.
- R2: `out_valid` equals the value `in_valid` had at the previous rising clock edge.
- R3: A word with exponent field (bits 30:23) between 1 and 254 appears on `out_word` unchanged, with `out_wrapped` low.
- R4: A word with exponent field 255 (infinity or NaN, any fraction) appears unchanged, with `out_wrapped` low.
- R5: A word with exponent field 0 and fraction (bits 22:0) zero appears unchanged, with `out_wrapped` low, for either sign.
- R6: A word with exponent field 0 and non-zero fraction sets `out_wrapped`. Let n be the number of zeros above the fraction's highest set bit. The output exponent field is then the 8-bit two's-complement encoding of -n. The output fraction is the input fraction shifted left by n+1, keeping the low 23 bits, with zeros filled in from the right.
- R7: The subnormal with fraction 1 yields exponent field 0xEA (-22) and a zero fraction, so positive sign gives 0x75000000.
- R8: The subnormal with fraction 0x7FFFFF yields exponent field 0x00 and fraction 0x7FFFFE, so positive sign gives 0x007FFFFE.
- R9: Bit 31 (sign) of `out_word` equals bit 31 of the accepted input in every case.
- R10: In a cycle where `in_valid` is low, `out_word` and `out_wrapped` keep their previous values.
- R11: Whenever `out_wrapped` is high, the output exponent field read as signed lies between -22 and 0 inclusive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_word` in this cycle |
| in_word | input | 32 | Single-precision operand |
| out_valid | output | 1 | A result accepted at the previous edge is present |
| out_word | output | 32 | Converted or passed-through word |
| out_wrapped | output | 1 | High when `out_word` uses the signed-exponent form |

## Verification
Every result is due exactly one rising edge after the edge that accepted its operand, and the hold behaviour applies on each edge where `in_valid` is low. The driver applies operands shortly after a rising edge and pushes the expected word and flag into a queue. The monitor samples on the falling edge that follows the next rising edge. At that point it compares `out_valid` against the `in_valid` captured one edge earlier, and pops one expectation for each valid result. Gaps in the input stream are followed by checks that the registered word and flag have not moved.

// File: rtl/dnw_pkg.sv
package dnw_pkg;

    // Operand category decided from the exponent and fraction fields.
    typedef enum logic [1:0] {
        CL_ZERO    = 2'd0,
        CL_SUB     = 2'd1,
        CL_NORM    = 2'd2,
        CL_SPECIAL = 2'd3
    } op_class_e;

    // Occupancy of the single output register.
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_LOADED = 1'b1
    } pipe_state_e;

endpackage

// File: rtl/dnw_classify.sv
module dnw_classify
    import dnw_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W-1:0] frac_i,
    output op_class_e         cls_o
);

    logic exp_zero;
    logic exp_full;
    logic frac_zero;

    assign exp_zero  = (exp_i == '0);
    assign exp_full  = (exp_i == '1);
    assign frac_zero = (frac_i == '0);

    always_comb begin
        if (exp_full) begin
            cls_o = CL_SPECIAL;
        end else if (!exp_zero) begin
            cls_o = CL_NORM;
        end else if (frac_zero) begin
            cls_o = CL_ZERO;
        end else begin
            cls_o = CL_SUB;
        end
    end

endmodule

// File: rtl/dnw_lzc.sv
module dnw_lzc #(
    parameter int W     = 23,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     vec_i,
    output logic [CNT_W-1:0] cnt_o
);

    // Scan from the least significant bit upward; the last set bit seen
    // is the highest one, so its distance from the top wins.
    always_comb begin
        cnt_o = CNT_W'(W);
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) begin
                cnt_o = CNT_W'(W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/dnw_renorm.sv
module dnw_renorm #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int CNT_W  = $clog2(FRAC_W + 1)
) (
    input  logic [FRAC_W-1:0] frac_i,
    input  logic [CNT_W-1:0]  lz_i,
    output logic [EXP_W-1:0]  exp_o,
    output logic [FRAC_W-1:0] frac_o
);

    localparam int SH_W = CNT_W + 1;

    logic [SH_W-1:0] shamt;

    // Shift past the leading one so it becomes the implicit bit.
    assign shamt  = SH_W'(lz_i) + SH_W'(1);
    assign frac_o = frac_i << shamt;

    // Signed exponent field: zero minus the leading-zero count.
    assign exp_o  = EXP_W'(0) - EXP_W'(lz_i);

endmodule

// File: rtl/dnw_conv.sv
module dnw_conv
    import dnw_pkg::*;
#(
    parameter  int EXP_W  = 8,
    parameter  int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              out_wrapped
);

    localparam int CNT_W    = $clog2(FRAC_W + 1);
    localparam int SIGN_POS = WORD_W - 1;
    localparam int MIN_EXP  = -(FRAC_W - 1);

    // Field split
    logic              in_sign;
    logic [EXP_W-1:0]  in_exp;
    logic [FRAC_W-1:0] in_frac;

    assign in_sign = in_word[SIGN_POS];
    assign in_exp  = in_word[FRAC_W +: EXP_W];
    assign in_frac = in_word[FRAC_W-1:0];

    // Datapath pieces
    op_class_e         cls;
    logic [CNT_W-1:0]  lz_cnt;
    logic [EXP_W-1:0]  rn_exp;
    logic [FRAC_W-1:0] rn_frac;

    dnw_classify #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W)
    ) u_classify (
        .exp_i  (in_exp),
        .frac_i (in_frac),
        .cls_o  (cls)
    );

    dnw_lzc #(
        .W     (FRAC_W),
        .CNT_W (CNT_W)
    ) u_lzc (
        .vec_i (in_frac),
        .cnt_o (lz_cnt)
    );

    dnw_renorm #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W),
        .CNT_W  (CNT_W)
    ) u_renorm (
        .frac_i (in_frac),
        .lz_i   (lz_cnt),
        .exp_o  (rn_exp),
        .frac_o (rn_frac)
    );

    // Result selection
    logic [WORD_W-1:0] nxt_word;
    logic              nxt_wrapped;

    always_comb begin
        unique case (cls)
            CL_SUB: begin
                nxt_word    = {in_sign, rn_exp, rn_frac};
                nxt_wrapped = 1'b1;
            end
            CL_ZERO, CL_NORM, CL_SPECIAL: begin
                nxt_word    = in_word;
                nxt_wrapped = 1'b0;
            end
            default: begin
                nxt_word    = in_word;
                nxt_wrapped = 1'b0;
            end
        endcase
    end

    // Occupancy state machine
    pipe_state_e state_q;
    pipe_state_e state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_LOADED : ST_IDLE;    // T_ACCEPT / stay
            ST_LOADED: state_d = in_valid ? ST_LOADED : ST_IDLE;    // stay / T_DRAIN
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_word    <= '0;
            out_wrapped <= 1'b0;
        end else if (in_valid) begin
            out_word    <= nxt_word;
            out_wrapped <= nxt_wrapped;
        end
    end

    assign out_valid = (state_q == ST_LOADED);

    // Checks on the port behaviour
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2

    AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2

    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_word[SIGN_POS] == $past(in_word[SIGN_POS]))); // R9

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !((in_word[FRAC_W +: EXP_W] == '0) && (in_word[FRAC_W-1:0] != '0)))
        |=> ((out_word == $past(in_word)) && !out_wrapped)); // R3

    AST_SUB_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_word[FRAC_W +: EXP_W] == '0) && (in_word[FRAC_W-1:0] != '0))
        |=> out_wrapped); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_word) && $stable(out_wrapped))); // R10

    AST_EXP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_wrapped |-> (($signed(out_word[FRAC_W +: EXP_W]) <= 0) &&
                         ($signed(out_word[FRAC_W +: EXP_W]) >= MIN_EXP))); // R11

endmodule

// File: tb/tb_dnw_conv.sv
module tb_dnw_conv;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_word;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_wrapped;

    dnw_conv dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_word     (in_word),
        .out_valid   (out_valid),
        .out_word    (out_word),
        .out_wrapped (out_wrapped)
    );

    typedef struct {
        logic [31:0] word;
        logic        wrapped;
        string       tag;
    } exp_item_t;

    exp_item_t   sb_q[$];
    int          n_checks = 0;
    int          n_fail   = 0;
    logic        prev_in  = 1'b0;
    logic [31:0] last_word = '0;
    logic        last_wr   = 1'b0;
    bit          done      = 1'b0;

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Independent reference of the conversion rules
    function automatic exp_item_t model(input logic [31:0] w, input string tag);
        exp_item_t   it;
        int          top;
        int          nz;
        logic [22:0] fr;
        fr         = w[22:0];
        it.tag     = tag;
        it.word    = w;
        it.wrapped = 1'b0;
        if (w[30:23] == 8'd0 && fr != 23'd0) begin
            top = 0;
            for (int b = 0; b < 23; b++) if (fr[b]) top = b;
            nz         = 22 - top;
            it.word    = {w[31], 8'(-nz), 23'(fr << (nz + 1))};
            it.wrapped = 1'b1;
        end
        return it;
    endfunction

    task automatic send(input logic [31:0] w, input string tag);
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_word  = w;
        sb_q.push_back(model(w, tag));
    endtask

    task automatic send_fixed(input logic [31:0] w, input logic [31:0] ew, input logic ewr, input string tag);
        exp_item_t it;
        @(posedge clk);
        #1;
        in_valid   = 1'b1;
        in_word    = w;
        it.word    = ew;
        it.wrapped = ewr;
        it.tag     = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
            in_valid = 1'b0;
            in_word  = 32'hDEAD_BEEF;
        end
    endtask

    // Capture of the accepted valid for the one-cycle latency rule
    always @(posedge clk) prev_in <= rst_n ? in_valid : 1'b0;

    // Monitor: compares at falling edges
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 out_valid", {31'd0, out_valid}, {31'd0, prev_in});
            if (out_valid) begin
                if (sb_q.size() == 0) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL R2 unexpected result actual=%h expected=none", out_word);
                end else begin
                    exp_item_t it;
                    it = sb_q.pop_front();
                    check({it.tag, " word"}, out_word, it.word);
                    check({it.tag, " flag"}, {31'd0, out_wrapped}, {31'd0, it.wrapped});
                    check("R9 sign", {31'd0, out_word[31]}, {31'd0, it.word[31]});
                    last_word = out_word;
                    last_wr   = out_wrapped;
                end
            end else begin
                check("R10 hold word", out_word, last_word);
                check("R10 hold flag", {31'd0, out_wrapped}, {31'd0, last_wr});
            end
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_word  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset valid", {31'd0, out_valid}, 32'd0);
        check("R1 reset word", out_word, 32'd0);
        check("R1 reset flag", {31'd0, out_wrapped}, 32'd0);
        #1 rst_n = 1'b1;
        idle(2);

        // R7 / R8 boundary subnormals with literal expectations
        send_fixed(32'h0000_0001, 32'h7500_0000, 1'b1, "R7 min sub");
        send_fixed(32'h007F_FFFF, 32'h007F_FFFE, 1'b1, "R8 max sub");
        send_fixed(32'h8000_0001, 32'hF500_0000, 1'b1, "R7 neg min sub");
        idle(2);

        // R5 zeros, R3 normals, R4 specials
        send(32'h0000_0000, "R5 +zero");
        send(32'h8000_0000, "R5 -zero");
        send(32'h0080_0000, "R3 min normal");
        send(32'h3F80_0000, "R3 one");
        send(32'hC2F6_E979, "R3 neg normal");
        send(32'h7F7F_FFFF, "R3 max normal");
        idle(1);
        send(32'h7F80_0000, "R4 +inf");
        send(32'hFF80_0000, "R4 -inf");
        send(32'h7FC0_0001, "R4 nan");
        idle(3);

        // R6 each leading-one position, with noise below it
        for (int p = 0; p < 23; p++) begin
            send({p[0], 8'h00, 23'(23'd1 << p) | 23'(23'h2A5A5A >> (23 - p))}, "R6 sub sweep");
            if (p % 5 == 4) idle(1);
        end
        idle(2);
        send(32'h0040_0000, "R6 top bit only");
        send(32'h8000_0400, "R6 mid bit neg");
        idle(4);

        done = 1'b1;
        if (sb_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2 leftover actual=%0d expected=0", sb_q.size());
        end
        finish_run();
    end

endmodule